// File: doc/BRIEF.md
# Decimating Interleave Buffer for a Parallel Wavelet Pipeline

This block sits between two filter stages of a linearised wavelet packet pipeline that handles P samples per clock. A fresh word of P samples comes in on every clock from the upstream filter. The block hands the downstream filter, which serves both the low-pass and the high-pass branch, a word stream that is decimated by two. Each kept word is shown for two clocks in a row, so the shared filter can take one branch on each presentation. Storage is plain registers. Each of the P lanes has its own sub-block, built from a fast chain that shifts every clock and a slow chain that shifts every second clock.

The stage index K sets the group length D = 2^K. A local modulo-D counter produces two strobes. A bulk-load strobe fires once per group and copies the even-numbered words of the fast chain into the slow chain all at once. A slow-shift strobe fires on every odd count. When both fall in the same cycle, the bulk load wins. The output is registered and is flagged valid once the first group has been loaded.

Top module: `decim_interleave_buf`

## Requirements
- R1: Under a synchronous active-high reset, `dout` is zero, `dout_valid` is low and `dout_repeat` is low at the first falling edge after a reset clock edge.
- R2: After reset is released, `dout_valid` stays low and `dout` stays zero for the first D-1 clock edges. `dout_valid` goes high on edge D and stays high until the next reset.
- R3: After clock edge e, counted from 1 after reset release, `dout_repeat` equals e mod 2. Every presented word is held for exactly two cycles: `dout_repeat` is 0 on the first cycle and 1 on the second.
- R4: Input words are numbered n = 0, 1, 2, ... from the first edge after reset and grouped as g = n div D. Starting at the edge that captures input gD+D-1, the block presents inputs gD, gD+2, ..., gD+D-2 in that order, each for two cycles. Odd-numbered inputs never appear.
- R5: On the clock where a group completes, a slow shift is also due (odd count). The bulk load wins, so the next output is the first even input of the new group and not the next word of the old one.
- R6: Lane p of `dout` (bits p*W+W-1 down to p*W) only ever carries lane p of `din` (the same bit positions).
- R7: A reset in the middle of a run clears the output and the valid flag and restarts the counter. Input numbering and grouping then begin again from the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | P*W | P samples from the upstream filter, lane p at bits p*W upward |
| dout | output | P*W | Decimated, twice-presented word for the downstream filter |
| dout_valid | output | 1 | High once the first group has been loaded |
| dout_repeat | output | 1 | 0 on the first presentation of a word, 1 on the second |

## Verification
The bulk load and the slow shift fall in the same cycle at the end of every group, because the last count of a group is odd. The bench provokes this simply by running many consecutive groups with patterns whose words are all distinct. At each group boundary it compares the word that appears after the load edge with the new group's first even input. If the shift had won, that word would instead be the zero fill or a stale word of the old group. The `dout_repeat` phase is judged on every cycle alongside it.

// File: rtl/decim_buf_pkg.sv
package decim_buf_pkg;

  // Strobes driven by the local controller to every lane.
  typedef struct packed {
    logic load;    // bulk copy fast -> slow
    logic shift;   // half-rate slow shift
    logic phase;   // low bit of the group counter
  } buf_strobe_t;

endpackage

// File: rtl/decim_buf_ctrl.sv
module decim_buf_ctrl
  import decim_buf_pkg::*;
#(
  parameter int K = 3
) (
  input  logic        clk,
  input  logic        rst,
  output buf_strobe_t stb,
  output logic        loaded
);

  logic [K-1:0] cnt;
  logic         last;

  assign last = &cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       loaded <= 1'b0;
    else if (last) loaded <= 1'b1;
  end

  // The load wins over the shift on the last (odd) count.
  always_comb begin
    stb.load  = last;
    stb.shift = cnt[0] & ~last;
    stb.phase = cnt[0];
  end

endmodule

// File: rtl/decim_buf_fast.sv
module decim_buf_fast #(
  parameter int W = 8,
  parameter int K = 3
) (
  input  logic                   clk,
  input  logic [W-1:0]           din,
  output logic [(1<<K)/2*W-1:0]  evens
);

  localparam int D  = 1 << K;
  localparam int FD = D - 1;
  localparam int S  = D / 2;

  logic [W-1:0] chain [FD];

  // No reset: every tap is refilled before the first load reads it.
  always_ff @(posedge clk) begin
    chain[0] <= din;
    for (int j = 1; j < FD; j++) chain[j] <= chain[j-1];
  end

  // Word m of the output is the m-th oldest even-numbered input.
  for (genvar m = 0; m < S; m++) begin : g_tap
    assign evens[m*W +: W] = chain[D-2-2*m];
  end

endmodule

// File: rtl/decim_buf_slow.sv
module decim_buf_slow #(
  parameter int W = 8,
  parameter int K = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic                   shift,
  input  logic [(1<<K)/2*W-1:0]  evens,
  output logic [W-1:0]           head
);

  localparam int S = (1 << K) / 2;

  logic [W-1:0] slot [S];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int m = 0; m < S; m++) slot[m] <= '0;
    end else if (load) begin
      for (int m = 0; m < S; m++) slot[m] <= evens[m*W +: W];
    end else if (shift) begin
      for (int m = 0; m < S-1; m++) slot[m] <= slot[m+1];
      slot[S-1] <= '0;
    end
  end

  assign head = slot[0];

endmodule

// File: rtl/decim_interleave_buf.sv
module decim_interleave_buf
  import decim_buf_pkg::*;
#(
  parameter int P = 4,
  parameter int W = 8,
  parameter int K = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [P*W-1:0] din,
  output logic [P*W-1:0] dout,
  output logic           dout_valid,
  output logic           dout_repeat
);

  localparam int S = (1 << K) / 2;

  buf_strobe_t stb;
  logic        loaded;

  decim_buf_ctrl #(.K(K)) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .loaded (loaded)
  );

  for (genvar p = 0; p < P; p++) begin : g_lane
    logic [S*W-1:0] evens;

    decim_buf_fast #(.W(W), .K(K)) i_fast (
      .clk   (clk),
      .din   (din[p*W +: W]),
      .evens (evens)
    );

    decim_buf_slow #(.W(W), .K(K)) i_slow (
      .clk   (clk),
      .rst   (rst),
      .load  (stb.load),
      .shift (stb.shift),
      .evens (evens),
      .head  (dout[p*W +: W])
    );
  end

  assign dout_valid  = loaded;
  assign dout_repeat = stb.phase;

endmodule

// File: rtl/decim_buf_checker.sv
module decim_buf_checker #(
  parameter int P = 4,
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [P*W-1:0] dout,
  input logic           dout_valid,
  input logic           dout_repeat
);

  AST_RESET_PHASE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!dout_repeat && !dout_valid)); // R1

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    dout_valid |=> dout_valid); // R2

  AST_EMPTY_BEFORE_VALID: assert property (@(posedge clk) disable iff (rst)
    !dout_valid |-> (dout == '0)); // R2

  AST_VALID_ON_FIRST_SHOW: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_valid) |-> !dout_repeat); // R2

  AST_PHASE_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dout_repeat != $past(dout_repeat))); // R3

  AST_WORD_HELD_TWICE: assert property (@(posedge clk) disable iff (rst)
    !dout_repeat |=> $stable(dout)); // R3

endmodule

bind decim_interleave_buf decim_buf_checker #(.P(P), .W(W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .dout        (dout),
  .dout_valid  (dout_valid),
  .dout_repeat (dout_repeat)
);

// File: tb/test_decim_interleave_buf.sv
`timescale 1ns/1ps
module test_decim_interleave_buf;

  localparam int P = 4;
  localparam int W = 8;
  localparam int K = 3;
  localparam int D = 1 << K;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [P*W-1:0] din = '0;
  logic [P*W-1:0] dout;
  logic           dout_valid;
  logic           dout_repeat;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  decim_interleave_buf #(.P(P), .W(W), .K(K)) i_decim_interleave_buf (
    .clk         (clk),
    .rst         (rst),
    .din         (din),
    .dout        (dout),
    .dout_valid  (dout_valid),
    .dout_repeat (dout_repeat)
  );

  function automatic logic [W-1:0] pat(int mode, int idx, int p);
    int v;
    case (mode)
      0:       v = idx * P + p;
      1:       v = p * 64 + idx;
      default: v = (idx * 29 + p * 113 + 7) ^ (idx * idx);
    endcase
    return v[W-1:0];
  endfunction

  function automatic logic [P*W-1:0] word(int mode, int idx);
    logic [P*W-1:0] w;
    for (int p = 0; p < P; p++) w[p*W +: W] = pat(mode, idx, p);
    return w;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R1 / R7: apply reset and look at the outputs it leaves.
  task automatic apply_reset(string tag);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(tag, 64'(dout), 64'd0);
    check(tag, 64'(dout_valid), 64'd0);
    check(tag, 64'(dout_repeat), 64'd0);
  endtask

  // Release reset at a falling edge and compare every cycle with the model.
  task automatic run(int mode, int ncyc, string dtag);
    rst = 1'b0;
    din = word(mode, 0);
    for (int e = 1; e <= ncyc; e++) begin
      @(posedge clk);
      @(negedge clk);
      check("R3", 64'(dout_repeat), 64'(e % 2));
      check("R2", 64'(dout_valid), 64'(e >= D));
      if (e < D) begin
        check("R2", 64'(dout), 64'd0);
      end else begin
        int t0 = (e / D) * D;
        int t  = e - t0;
        int g  = t0 / D - 1;
        int ix = g * D + 2 * (t / 2);
        check((t == 0 && e >= 2 * D) ? "R5" : dtag, 64'(dout), 64'(word(mode, ix)));
      end
      din = word(mode, e);
    end
  endtask

  task automatic test_reset;
    apply_reset("R1");
  endtask

  task automatic test_ramp;       // R4, R5
    run(0, 6 * D, "R4");
  endtask

  task automatic test_lanes;      // R6
    apply_reset("R1");
    run(1, 4 * D, "R6");
  endtask

  task automatic test_midreset;   // R7
    apply_reset("R1");
    run(2, D + 3, "R4");
    apply_reset("R7");
    run(2, 4 * D, "R7");
  endtask

  initial begin
    test_reset();
    test_ramp();
    test_lanes();
    test_midreset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule